// File: doc/BRIEF.md
# Combined Arithmetic, Logic and Shift Unit

This block takes two n-bit two's-complement operands and produces one n-bit result from one of four paths: arithmetic, bitwise logic, a one-place shift toward the LSB, or a one-place shift toward the MSB. A two-bit path select chooses the path. Three function-select bits pick the operation inside the chosen path. For the two shift paths, the function bits also choose a logical, arithmetic or rotate shift. All four paths are computed in parallel. The selected value is captured into a result register on a rising clock edge, but only while the load enable is high.

A one-bit overflow flag is captured with the result. It is set only by an arithmetic shift toward the MSB. In that case it is the exclusive OR of the two most significant operand bits before the shift, so it is 1 when doubling the value would change its sign. A serial-in pin supplies the bit that enters the vacated end during a logical shift.

Operands, selects and the load enable are plain level inputs. There is no valid/ready handshake and no back-pressure: the result register accepts a new value on every edge where the load enable is high, and the caller holds the inputs stable around that edge.

Top module: `alsu_top`

## Requirements
- R1: While rst_n is low, result_q and ovf_q are 0, whatever the other inputs are.
- R2: result_q and ovf_q change only on a rising clk edge where load_en is 1. On any edge where load_en is 0 they keep their values.
- R3: With path_sel = 2'b00 (arithmetic), func_sel selects the result, taken modulo 2^WIDTH:
  - 3'b000 gives A+B
  - 3'b001 gives A+B+1
  - 3'b010 gives A+~B+1
  - 3'b011 gives A+1
  - 3'b100 gives A-1
  - 3'b101, 3'b110 and 3'b111 give A unchanged
- R4: With path_sel = 2'b01 (logic), func_sel[1:0] selects the result: 2'b00 gives A AND B, 2'b01 gives A OR B, 2'b10 gives A XOR B, 2'b11 gives NOT A. func_sel[2] has no effect.
- R5: With path_sel = 2'b10 (shift right) and func_sel[1:0] = 2'b00, the result is A shifted one place toward the LSB, with serial_in entering the MSB.
- R6: With path_sel = 2'b10 and func_sel[1:0] = 2'b01, the result is an arithmetic right shift: the sign bit A[WIDTH-1] is kept, and the other bits move one place toward the LSB.
- R7: With path_sel = 2'b11 (shift left) and func_sel[1:0] = 2'b00, the result is A shifted one place toward the MSB, with serial_in entering bit 0.
- R8: With path_sel = 2'b11 and func_sel[1:0] = 2'b01, the result is A shifted toward the MSB with 0 entering bit 0. ovf_q becomes A[WIDTH-1] XOR A[WIDTH-2], taken before the shift.
- R9: With a shift path and func_sel[1] = 1, the result is a rotate by one place: on path 2'b10, A[0] enters the MSB; on path 2'b11, A[WIDTH-1] enters bit 0. In both shift paths func_sel[2] has no effect.
- R10: After any load other than the one named in R8, ovf_q is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Capture the selected result on this edge |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| path_sel | input | 2 | 00 arithmetic, 01 logic, 10 shift right, 11 shift left |
| func_sel | input | 3 | Operation within the selected path |
| serial_in | input | 1 | Bit entering the vacated end during a logical shift |
| result_q | output | WIDTH | Registered result |
| ovf_q | output | 1 | Registered overflow of an arithmetic left shift |

## Verification
The only state is the result register and the flag register. A wrong captured value therefore appears on result_q or ovf_q at the first sample after the loading edge, one cycle after the inputs were applied. A register that updates when it should hold shows up on the following idle cycle: the operands and selects are changed there, and the outputs must not move. A wrong path or function decode gives a mismatch for nearly every operand pair of the affected code. An exhaustive sweep over a 4-bit configuration therefore exposes it within a few cycles of that code's turn.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [1:0] {
    PATH_ARITH = 2'b00,
    PATH_LOGIC = 2'b01,
    PATH_SHR   = 2'b10,
    PATH_SHL   = 2'b11
  } path_e;

  localparam logic [1:0] SHK_LOGICAL = 2'b00;
  localparam logic [1:0] SHK_ARITH   = 2'b01;
endpackage

// File: rtl/alsu_arith.sv
module alsu_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       func,
  output logic [WIDTH-1:0] y
);
  logic [WIDTH-1:0] addend;
  logic             cin;

  // Every arithmetic code is A + addend + carry; only the addend and the carry vary.
  always_comb begin
    case (func)
      3'b000:  begin addend = b;               cin = 1'b0; end
      3'b001:  begin addend = b;               cin = 1'b1; end
      3'b010:  begin addend = ~b;              cin = 1'b1; end
      3'b011:  begin addend = '0;              cin = 1'b1; end
      3'b100:  begin addend = {WIDTH{1'b1}};   cin = 1'b0; end
      default: begin addend = '0;              cin = 1'b0; end
    endcase
  end

  assign y = a + addend + {{(WIDTH-1){1'b0}}, cin};
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       func,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    case (func)
      2'b00:   y = a & b;
      2'b01:   y = a | b;
      2'b10:   y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int WIDTH = 8,
  parameter bit LEFT  = 1'b0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [1:0]       kind,
  input  logic             serial_in,
  output logic [WIDTH-1:0] y
);
  import alsu_pkg::*;

  generate
    if (LEFT) begin : g_left
      always_comb begin
        if (kind[1])                  y = {a[WIDTH-2:0], a[WIDTH-1]};
        else if (kind == SHK_ARITH)   y = {a[WIDTH-2:0], 1'b0};
        else                          y = {a[WIDTH-2:0], serial_in};
      end
    end else begin : g_right
      always_comb begin
        if (kind[1])                  y = {a[0], a[WIDTH-1:1]};
        else if (kind == SHK_ARITH)   y = {a[WIDTH-1], a[WIDTH-1:1]};
        else                          y = {serial_in, a[WIDTH-1:1]};
      end
    end
  endgenerate
endmodule

// File: rtl/alsu_top.sv
module alsu_top #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       path_sel,
  input  logic [2:0]       func_sel,
  input  logic             serial_in,
  output logic [WIDTH-1:0] result_q,
  output logic             ovf_q
);
  import alsu_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] arith_y, logic_y, shr_y, shl_y, result_d;
  logic             ovf_d;
  path_e            path;

  assign path = path_e'(path_sel);

  alsu_arith #(.WIDTH(WIDTH)) arith_i (
    .a(opa), .b(opb), .func(func_sel), .y(arith_y));

  alsu_logic #(.WIDTH(WIDTH)) logic_i (
    .a(opa), .b(opb), .func(func_sel[1:0]), .y(logic_y));

  alsu_shift #(.WIDTH(WIDTH), .LEFT(1'b0)) shr_i (
    .a(opa), .kind(func_sel[1:0]), .serial_in(serial_in), .y(shr_y));

  alsu_shift #(.WIDTH(WIDTH), .LEFT(1'b1)) shl_i (
    .a(opa), .kind(func_sel[1:0]), .serial_in(serial_in), .y(shl_y));

  always_comb begin
    case (path)
      PATH_ARITH: result_d = arith_y;
      PATH_LOGIC: result_d = logic_y;
      PATH_SHR:   result_d = shr_y;
      default:    result_d = shl_y;
    endcase
  end

  // A sign change on doubling is seen from the two top bits before the shift.
  assign ovf_d = (path == PATH_SHL) && (func_sel[1:0] == SHK_ARITH)
                 && (opa[MSB] ^ opa[MSB-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else if (load_en) begin
      result_q <= result_d;
      ovf_q    <= ovf_d;
    end
  end
endmodule

// File: rtl/alsu_chk.sv
module alsu_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [1:0]       path_sel,
  input logic [2:0]       func_sel,
  input logic             serial_in,
  input logic [WIDTH-1:0] result_q,
  input logic             ovf_q
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(result_q) && $stable(ovf_q)));

  assert_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && path_sel == 2'b01 && func_sel[1:0] == 2'b00)
      |=> result_q == ($past(opa) & $past(opb)));

  assert_asr_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && path_sel == 2'b10 && func_sel[1:0] == 2'b01)
      |=> result_q[WIDTH-1] == $past(opa[WIDTH-1]));

  assert_asl_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && path_sel == 2'b11 && func_sel[1:0] == 2'b01)
      |=> ovf_q == ($past(opa[WIDTH-1]) ^ $past(opa[WIDTH-2])));

  assert_rotl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && path_sel == 2'b11 && func_sel[1])
      |=> result_q[0] == $past(opa[WIDTH-1]));

  assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !(path_sel == 2'b11 && func_sel[1:0] == 2'b01)) |=> !ovf_q);
endmodule

bind alsu_top alsu_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .opa(opa), .opb(opb),
  .path_sel(path_sel), .func_sel(func_sel), .serial_in(serial_in),
  .result_q(result_q), .ovf_q(ovf_q));

// File: tb/alsu_top_tb_top.sv
`timescale 1ns/1ps
module alsu_top_tb_top;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [1:0]   path_sel = '0;
  logic [2:0]   func_sel = '0;
  logic         serial_in = 1'b0;
  logic [W-1:0] result_q;
  logic         ovf_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alsu_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .opa(opa), .opb(opb),
    .path_sel(path_sel), .func_sel(func_sel), .serial_in(serial_in),
    .result_q(result_q), .ovf_q(ovf_q));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (path=%0d func=%0d a=%0d b=%0d si=%0d)",
               req, act, exp, path_sel, func_sel, opa, opb, serial_in);
    end
  endtask

  // Reference: low W bits hold the result, bit W the overflow flag.
  function automatic int model(int a, int b, int path, int func, int si);
    int r = 0;
    int ov = 0;
    int k = func % 4;
    case (path)
      0: begin
        case (func)
          0: r = a + b;
          1: r = a + b + 1;
          2: r = a - b;
          3: r = a + 1;
          4: r = a - 1;
          default: r = a;
        endcase
        r = ((r % M) + M) % M;
      end
      1: begin
        case (k)
          0: r = a & b;
          1: r = a | b;
          2: r = a ^ b;
          default: r = (M - 1) - a;
        endcase
      end
      2: begin
        if (k >= 2)      r = (a >> 1) | ((a & 1) << (W - 1));
        else if (k == 1) r = (a >> 1) | (a & (M / 2));
        else             r = (a >> 1) | (si << (W - 1));
      end
      default: begin
        if (k >= 2)      r = ((a << 1) % M) | (a >> (W - 1));
        else if (k == 1) begin
          r  = (a << 1) % M;
          ov = ((a >> (W - 1)) & 1) ^ ((a >> (W - 2)) & 1);
        end
        else             r = ((a << 1) % M) | si;
      end
    endcase
    return r + ov * M;
  endfunction

  function automatic string req_of(int path, int func);
    int k = func % 4;
    if (path == 0) return "R3";
    if (path == 1) return "R4";
    if (k >= 2) return "R9";
    if (path == 2) return (k == 1) ? "R6" : "R5";
    return (k == 1) ? "R8" : "R7";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    // R1: outputs stay clear in reset even with a load requested.
    load_en = 1'b1; opa = 4'hF; opb = 4'h3; path_sel = 2'b00; func_sel = 3'b001;
    repeat (3) begin
      @(negedge clk);
      check("R1 result", int'(result_q), 0);
      check("R1 ovf", int'(ovf_q), 0);
    end
    load_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(result_q), 0);

    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 8; f++)
        for (int s = 0; s < 2; s++)
          for (int a = 0; a < M; a++)
            for (int b = 0; b < M; b++) begin
              int exp;
              exp = model(a, b, p, f, s);
              opa = W'(a); opb = W'(b); path_sel = 2'(p); func_sel = 3'(f);
              serial_in = s[0]; load_en = 1'b1;
              @(negedge clk);
              check(req_of(p, f), int'(result_q), exp % M);
              check((p == 3 && f % 4 == 1) ? "R8 ovf" : "R10 ovf",
                    int'(ovf_q), exp / M);
              // R2: different inputs with load low must not disturb the outputs.
              load_en = 1'b0; opa = ~W'(a); opb = ~W'(b);
              path_sel = 2'(3 - p); func_sel = 3'(7 - f); serial_in = ~s[0];
              @(negedge clk);
              check("R2 hold result", int'(result_q), exp % M);
              check("R2 hold ovf", int'(ovf_q), exp / M);
            end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule